// File: doc/BRIEF.md
# GF(2^89) Almost-Inverse Reciprocal Unit

This block computes the multiplicative inverse of a nonzero element of GF(2^89). The field polynomial is u^89 + u^38 + 1. It works in two phases. The first phase is an almost-inverse loop. It keeps two working polynomials and two companion polynomials, and it tracks a power count k. When the first working polynomial reaches 1, the upper companion holds a^(-1)·u^k.

The second phase divides out u^k. It strips up to eight powers of u in each cycle. The rest of k below eight is removed in one last partial step.

The unit is driven by a start pulse. It answers with a one-cycle done pulse and holds the 89-bit result until the next operation. Three hardware choices shorten the loop:
- Swaps are decided by a degree comparison built from magnitude comparators, with no leading-one encoders.
- Trailing zeros are removed up to two positions per cycle.
- The fix-up phase clears eight low bits per cycle by adding a multiple of the field polynomial.

An input of zero cannot be inverted. It is rejected at once with an error flag.

Top module: `almost_inv_gf2m`

## Requirements
- R1: After reset, busy, done and err are 0 and inv is all zeros.
- R2: For any nonzero a, the value on inv when done pulses satisfies a·inv mod (u^89 + u^38 + 1) = 1. Here bit i of a vector is the coefficient of u^i.
- R3: Input a = 1 returns inv = 1.
- R4: Input a = 0 gives done and err high on the edge after start, with inv all zeros and busy never raised. A nonzero operation clears err.
- R5: A start pulse while busy is high is ignored. The running operation still returns the inverse of its own input, and no extra operation follows.
- R6: done is high for exactly one cycle. busy rises on the edge after an accepted nonzero start and falls on the same edge where done rises.
- R7: Between done and the next accepted start, inv and err stay constant, whatever a does.
- R8: A nonzero operation completes within 5·89 = 445 cycles of the start edge.
- R9: Input a = u (value 2) returns u^88 + u^37, which is bits 88 and 37 set. This case exercises a single radix-4/radix-2 shift and a one-bit fix-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts an inversion of a when idle |
| a | input | 89 | Element to invert |
| busy | output | 1 | Inversion in progress |
| done | output | 1 | One-cycle pulse: inv and err are valid |
| err | output | 1 | Last request was a zero input |
| inv | output | 89 | Inverse of the last accepted input |

## Verification
The bench targets several corner cases:
- a = 1 skips both the shift and swap work. A design that mishandles the k = 0 path would return a value that is not 1.
- a = u needs an odd-length fix-up. A wrong partial-step mask would leave a stray u factor.
- Inputs with dense upper bits press the degree comparison. A wrong swap decision drives the loop past its latency bound or yields a product other than 1.
- Zero, starts during a busy operation, and toggling a after done check the guarding logic. A faulty guard would hang, restart, or corrupt the held result.

// File: rtl/almost_inv_gf2m.sv
module almost_inv_gf2m #(
  parameter int N   = 89,
  parameter int TAP = 38,
  parameter int KW  = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N-1:0] a,
  output logic         busy,
  output logic         done,
  output logic         err,
  output logic [N-1:0] inv
);
  localparam int W  = N + 2;
  localparam int EW = W + 8;
  localparam logic [W-1:0] MOD = (W'(1) << N) | (W'(1) << TAP) | W'(1);

  typedef enum logic [1:0] {S_IDLE, S_LOOP, S_FIX} st_t;
  st_t st;

  logic [W-1:0]  f, g, b, c;
  logic [KW-1:0] k;

  logic          swap;
  logic [W-1:0]  fs, gs, bs, cs;
  logic [3:0]    s;
  logic [EW-1:0] mask, t, ext;
  logic [W-1:0]  nb;
  logic [N-1:0]  red;

  assign swap = ((f ^ g) > f) && (f < g);
  assign fs = swap ? g : f;
  assign gs = swap ? f : g;
  assign bs = swap ? c : b;
  assign cs = swap ? b : c;

  assign s    = (k >= KW'(8)) ? 4'd8 : {1'b0, k[2:0]};
  assign mask = (EW'(1) << s) - EW'(1);
  assign t    = EW'(b) & mask;
  assign ext  = EW'(b) ^ t ^ (t << TAP) ^ (t << N);
  assign nb   = W'(ext >> s);
  assign red  = b[N-1:0] ^ (b[N] ? MOD[N-1:0] : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      f    <= '0;
      g    <= '0;
      b    <= '0;
      c    <= '0;
      k    <= '0;
      busy <= 1'b0;
      done <= 1'b0;
      err  <= 1'b0;
      inv  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (a == '0) begin
            done <= 1'b1;
            err  <= 1'b1;
            inv  <= '0;
          end else begin
            f    <= W'(a);
            g    <= MOD;
            b    <= W'(1);
            c    <= '0;
            k    <= '0;
            err  <= 1'b0;
            busy <= 1'b1;
            st   <= S_LOOP;
          end
        end
        S_LOOP: begin
          if (f == W'(1)) begin
            st <= S_FIX;
          end else if (!f[0]) begin
            if (!f[1]) begin
              f <= f >> 2;
              c <= c << 2;
              k <= k + KW'(2);
            end else begin
              f <= f >> 1;
              c <= c << 1;
              k <= k + KW'(1);
            end
          end else begin
            f <= fs ^ gs;
            g <= gs;
            b <= bs ^ cs;
            c <= cs;
          end
        end
        S_FIX: begin
          if (k == '0) begin
            inv  <= red;
            done <= 1'b1;
            busy <= 1'b0;
            st   <= S_IDLE;
          end else begin
            b <= nb;
            k <= k - KW'(s);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module almost_inv_gf2m_chk #(
  parameter int N = 89
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [N-1:0] a,
  input logic         busy,
  input logic         done,
  input logic         err,
  input logic [N-1:0] inv
);
  localparam int LIM = 5 * N;
  int unsigned cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= 0;
    else if (busy) cnt <= cnt + 1;
    else cnt <= 0;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && a != '0) |=> busy); // R6
  AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && done) |-> 1'b0); // R6
  AST_ZERO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && a == '0) |=> (done && err && !busy && inv == '0)); // R4
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !busy) |-> ($stable(inv) && $stable(err))); // R7
  AST_BUSY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done)); // R5
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < LIM)); // R8
endmodule

bind almost_inv_gf2m almost_inv_gf2m_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .a(a),
  .busy(busy), .done(done), .err(err), .inv(inv)
);

// File: tb/tb_almost_inv_gf2m.sv
module tb_almost_inv_gf2m;
  localparam int N = 89;
  localparam logic [N:0] MODP = (90'(1) << N) | (90'(1) << 38) | 90'(1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [N-1:0] a = '0;
  logic busy, done, err;
  logic [N-1:0] inv;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  almost_inv_gf2m dut (.clk(clk), .rst_n(rst_n), .start(start), .a(a),
                       .busy(busy), .done(done), .err(err), .inv(inv));

  always #4 clk = ~clk;

  function automatic logic [N-1:0] mulmod(input logic [N-1:0] x, input logic [N-1:0] y);
    logic [N:0] r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      r = r << 1;
      if (r[N]) r = r ^ MODP;
      if (y[i]) r = r ^ {1'b0, x};
    end
    return r[N-1:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [N-1:0] val, output logic [N-1:0] res, output int cyc);
    @(negedge clk);
    a = val;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    res = inv;
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] res, v, held;
    int cyc;
    int seen;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && inv == '0, "R1", inv, '0);
    rst_n = 1'b1;
    @(negedge clk);

    run(89'd1, res, cyc);
    chk(res == 89'd1, "R3", res, 89'd1);

    run(89'd2, res, cyc);
    v = (89'(1) << 88) | (89'(1) << 37);
    chk(res == v, "R9", res, v);

    @(negedge clk);
    a = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done && err && !busy && inv == '0, "R4", inv, '0);

    run(89'd3, res, cyc);
    chk(!err && mulmod(89'd3, res) == 89'd1, "R4 err cleared / R2", mulmod(89'd3, res), 89'd1);

    v = '1;
    run(v, res, cyc);
    chk(mulmod(v, res) == 89'd1, "R2 all ones", mulmod(v, res), 89'd1);
    chk(cyc <= 5 * N, "R8 all ones", 89'(cyc), 89'(5 * N));

    v = 89'(1) << 88;
    run(v, res, cyc);
    chk(mulmod(v, res) == 89'd1, "R2 top bit", mulmod(v, res), 89'd1);

    for (int i = 0; i < 40; i++) begin
      v = {$urandom(), $urandom(), $urandom()};
      if (i % 5 == 0) v = v | (89'(1) << 88);
      if (v == '0) v = 89'd5;
      run(v, res, cyc);
      chk(mulmod(v, res) == 89'd1, "R2 random", mulmod(v, res), 89'd1);
      chk(cyc <= 5 * N, "R8 random", 89'(cyc), 89'(5 * N));
    end

    v = 89'h1_2345_6789_abcd_ef01_2345;
    @(negedge clk);
    a = v;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R6 busy rise", 89'(busy), 89'd1);
    @(negedge clk);
    a = 89'd7;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    a = '0;
    seen = 0;
    for (int i = 0; i < 600; i++) begin
      if (done) begin
        seen++;
        if (seen == 1) begin
          res = inv;
          chk(!busy, "R6 busy fall", 89'(busy), 89'd0);
        end
      end
      @(negedge clk);
    end
    chk(seen == 1, "R5/R6 single done", 89'(seen), 89'd1);
    chk(mulmod(v, res) == 89'd1, "R5 result", mulmod(v, res), 89'd1);

    held = inv;
    for (int i = 0; i < 5; i++) begin
      a = {$urandom(), $urandom(), $urandom()};
      @(negedge clk);
    end
    chk(inv == held && !err, "R7 hold", inv, held);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule